// File: doc/BRIEF.md
# Edge-Notification Interrupt Controller

This block watches a group of already-conditioned digital input lines and reports when any of them changes in a way software has asked to hear about. Every line carries two enable bits, one for a low-to-high change and one for a high-to-low change. Two global gates in a small control register switch each edge direction on or off for all lines together. A change is found by comparing each line's current sample with the sample from the clock before.

When a qualifying change is seen, a sticky edge flag is set. If another qualifying change arrives while that flag is still set, a sticky overflow flag is set as well. An interrupt line is driven high when the interrupt is enabled and at least one flag is set whose own source enable is on. Software reaches the enables, the control byte, the status byte and a write-one-to-clear byte through a simple byte-wide register port.

The usual flow is to clear any stale flags, enable interrupts, and clear the flags again after each interrupt has been serviced. A clear that lands in the same cycle as a new change never hides that change.

Top module: `cni_intc`

## Requirements
- R1: After reset, the control byte, the status byte and every enable byte read 0, and `irq_o` is low.
- R2: Rising enables live at byte addresses 0x18 upward and falling enables at 0x20 upward. Byte k holds lines 8k to 8k+7, with bit 0 mapped to line 8k. Each enable byte reads back the value last written to it.
- R3: A low-to-high change on a line whose rising enable is set, while control bit 3 (rising gate) is set, sets status bit 0 (edge) at the next clock edge.
- R4: A high-to-low change on a line whose falling enable is set, while control bit 4 (falling gate) is set, sets status bit 0 at the next clock edge.
- R5: A change is ignored when the line's enable for that direction is clear, or when the gate for that direction is clear. In both cases the status does not change.
- R6: A qualifying change that arrives while the edge flag is set, and is not being cleared in that cycle, sets status bit 1 (overflow). The overflow flag then stays set until it is cleared.
- R7: Writing to the clear byte at 0x07 with bit 3 set clears the edge flag, and with bit 2 set clears the overflow flag. Both bits may be set in one write. The clear byte reads 0.
- R8: When a clear of the edge flag and a new qualifying change occur in the same cycle, the edge flag stays set and no overflow is recorded.
- R9: `irq_o` is high exactly when control bit 2 is set and either (edge flag and control bit 0) or (overflow flag and control bit 1) holds. Status bit 2 always equals `irq_o`. The status byte is at 0x14.
- R10: The control byte at 0x15 reads back bits 4:0 as written, and bits 7:5 read 0.
- R11: Writes to the status byte have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| din_i | input | NUM_CH | Sampled input lines |
| reg_wr_i | input | 1 | Register write strobe, one byte per cycle |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: 24 lines across three enable bytes per direction, a 6-bit address, and the combinational interrupt variant. With that setup, changes on the first, middle and last lines of the group all produce a visible edge flag, and the status byte shows a new interrupt in the same sample as the edge flag. The table-driven part sweeps the combinations of per-line enable, direction and global gate. The directed part creates overflow, performs partial clears, turns the interrupt-source enable off and back on, and makes a clear coincide with a new change.

// File: rtl/cni_pkg.sv
package cni_pkg;

   // control byte layout (bit 4 down to bit 0)
   typedef struct packed {
      logic fall_gate;
      logic rise_gate;
      logic irq_en;
      logic ovf_en;
      logic edge_en;
   } cni_ctrl_t;

   localparam int CTRL_W       = 5;
   localparam int STAT_EDGE    = 0;
   localparam int STAT_OVF     = 1;
   localparam int STAT_IRQ     = 2;
   localparam int CLR_EDGE_BIT = 3;
   localparam int CLR_OVF_BIT  = 2;

endpackage

// File: rtl/cni_enable_bank.sv
module cni_enable_bank #(
   parameter int NUM_CH = 24,
   parameter int ADDR_W = 6,
   parameter int BASE   = 'h18
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [NUM_CH-1:0] en_o,
   output logic              hit_o,
   output logic [7:0]        rdata_o
);
   localparam int NUM_BYTES = (NUM_CH + 7) / 8;

   logic [NUM_BYTES*8-1:0] bank_w;

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      localparam int LO              = b * 8;
      localparam int WIDTH           = ((NUM_CH - LO) >= 8) ? 8 : (NUM_CH - LO);
      localparam logic [7:0] MASK    = 8'((1 << WIDTH) - 1);
      localparam logic [ADDR_W-1:0] ADR = ADDR_W'(BASE + b);

      logic [7:0] byte_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            byte_q <= '0;
         end else if (wr_i && (addr_i == ADR)) begin
            byte_q <= wdata_i & MASK;
         end
      end

      assign bank_w[LO +: 8] = byte_q;
   end

   assign en_o = bank_w[NUM_CH-1:0];

   always_comb begin
      hit_o   = 1'b0;
      rdata_o = '0;
      for (int i = 0; i < NUM_BYTES; i++) begin
         if (addr_i == ADDR_W'(BASE + i)) begin
            hit_o   = 1'b1;
            rdata_o = bank_w[i*8 +: 8];
         end
      end
   end

endmodule

// File: rtl/cni_edge_detect.sv
module cni_edge_detect #(
   parameter int NUM_CH = 24
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] sample_i,
   input  logic [NUM_CH-1:0] rise_en_i,
   input  logic [NUM_CH-1:0] fall_en_i,
   input  logic              rise_gate_i,
   input  logic              fall_gate_i,
   output logic              event_o
);
   logic [NUM_CH-1:0] prev_q;
   logic [NUM_CH-1:0] rise_hit;
   logic [NUM_CH-1:0] fall_hit;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q <= '0;
      end else begin
         prev_q <= sample_i;
      end
   end

   assign rise_hit = sample_i & ~prev_q & rise_en_i & {NUM_CH{rise_gate_i}};
   assign fall_hit = ~sample_i & prev_q & fall_en_i & {NUM_CH{fall_gate_i}};
   assign event_o  = |(rise_hit | fall_hit);

endmodule

// File: rtl/cni_event_status.sv
module cni_event_status
   import cni_pkg::*;
#(
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      event_i,
   input  logic      clr_edge_i,
   input  logic      clr_ovf_i,
   input  cni_ctrl_t ctrl_i,
   output logic      edge_q_o,
   output logic      ovf_q_o,
   output logic      irq_o
);
   logic edge_q;
   logic ovf_q;
   logic irq_raw;

   // a new event beats a same-cycle clear; overflow only against a surviving flag
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         edge_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         edge_q <= event_i | (edge_q & ~clr_edge_i);
         ovf_q  <= (event_i & edge_q & ~clr_edge_i) | (ovf_q & ~clr_ovf_i);
      end
   end

   assign irq_raw = ctrl_i.irq_en &
                    ((edge_q & ctrl_i.edge_en) | (ovf_q & ctrl_i.ovf_en));

   if (IRQ_REGISTERED) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= irq_raw;
         end
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_raw;
   end

   assign edge_q_o = edge_q;
   assign ovf_q_o  = ovf_q;

endmodule

// File: rtl/cni_intc.sv
module cni_intc
   import cni_pkg::*;
#(
   parameter int NUM_CH         = 24,
   parameter int ADDR_W         = 6,
   parameter int CLR_ADDR       = 'h07,
   parameter int STAT_ADDR      = 'h14,
   parameter int CTRL_ADDR      = 'h15,
   parameter int RISE_BASE      = 'h18,
   parameter int FALL_BASE      = 'h20,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] din_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [7:0]        reg_wdata_i,
   output logic [7:0]        reg_rdata_o,
   output logic              irq_o
);
   localparam int NUM_BYTES = (NUM_CH + 7) / 8;
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

   // elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_width
      $error("cni_intc: NUM_CH must be within 1..64");
   end
   if (RISE_BASE + NUM_BYTES > FALL_BASE) begin : g_bad_overlap
      $error("cni_intc: rising bank overlaps falling bank");
   end
   if (FALL_BASE + NUM_BYTES > (1 << ADDR_W)) begin : g_bad_span
      $error("cni_intc: enable banks exceed the address space");
   end
   if (CLR_ADDR >= RISE_BASE || STAT_ADDR >= RISE_BASE || CTRL_ADDR >= RISE_BASE ||
       CLR_ADDR == STAT_ADDR || CLR_ADDR == CTRL_ADDR || STAT_ADDR == CTRL_ADDR)
   begin : g_bad_single
      $error("cni_intc: single-byte registers collide");
   end

   cni_ctrl_t         ctrl_q;
   logic [NUM_CH-1:0] rise_en;
   logic [NUM_CH-1:0] fall_en;
   logic              rise_hit;
   logic              fall_hit;
   logic [7:0]        rise_rdata;
   logic [7:0]        fall_rdata;
   logic              edge_event;
   logic              clr_edge;
   logic              clr_ovf;
   logic              edge_q;
   logic              ovf_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
      end else if (reg_wr_i && (reg_addr_i == A_CTRL)) begin
         ctrl_q <= cni_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
      end
   end

   assign clr_edge = reg_wr_i && (reg_addr_i == A_CLR) && reg_wdata_i[CLR_EDGE_BIT];
   assign clr_ovf  = reg_wr_i && (reg_addr_i == A_CLR) && reg_wdata_i[CLR_OVF_BIT];

   cni_enable_bank #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .BASE   (RISE_BASE)
   ) u_rise_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_wr_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .en_o    (rise_en),
      .hit_o   (rise_hit),
      .rdata_o (rise_rdata)
   );

   cni_enable_bank #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .BASE   (FALL_BASE)
   ) u_fall_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_wr_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .en_o    (fall_en),
      .hit_o   (fall_hit),
      .rdata_o (fall_rdata)
   );

   cni_edge_detect #(
      .NUM_CH (NUM_CH)
   ) u_detect (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sample_i    (din_i),
      .rise_en_i   (rise_en),
      .fall_en_i   (fall_en),
      .rise_gate_i (ctrl_q.rise_gate),
      .fall_gate_i (ctrl_q.fall_gate),
      .event_o     (edge_event)
   );

   cni_event_status #(
      .IRQ_REGISTERED (IRQ_REGISTERED)
   ) u_status (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .event_i    (edge_event),
      .clr_edge_i (clr_edge),
      .clr_ovf_i  (clr_ovf),
      .ctrl_i     (ctrl_q),
      .edge_q_o   (edge_q),
      .ovf_q_o    (ovf_q),
      .irq_o      (irq_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      if (rise_hit) begin
         reg_rdata_o = rise_rdata;
      end else if (fall_hit) begin
         reg_rdata_o = fall_rdata;
      end else if (reg_addr_i == A_STAT) begin
         reg_rdata_o[STAT_EDGE] = edge_q;
         reg_rdata_o[STAT_OVF]  = ovf_q;
         reg_rdata_o[STAT_IRQ]  = irq_o;
      end else if (reg_addr_i == A_CTRL) begin
         reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      end
   end

endmodule

// File: rtl/cni_intc_checker.sv
module cni_intc_checker #(
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       edge_event,
   input logic       edge_q,
   input logic       ovf_q,
   input logic       clr_edge,
   input logic       clr_ovf,
   input logic [4:0] ctrl_bits,
   input logic       irq_o
);

   AST_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_event |=> edge_q); // R3

   AST_GATES_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_bits[4] && !ctrl_bits[3]) |-> !edge_event); // R5

   AST_OVF_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_event && edge_q && !clr_edge) |=> ovf_q); // R6

   AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_q && !clr_ovf) |=> ovf_q); // R6

   AST_EDGE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_edge && !edge_event) |=> !edge_q); // R7

   AST_RACE_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_edge && edge_event) |=> (edge_q && $stable(ovf_q) || edge_q && !ovf_q)); // R8

   if (!IRQ_REGISTERED) begin : g_comb_irq_chk
      AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o |-> (ctrl_bits[2] && (edge_q || ovf_q))); // R9
   end

endmodule

bind cni_intc cni_intc_checker #(
   .IRQ_REGISTERED (IRQ_REGISTERED)
) u_cni_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .edge_event (edge_event),
   .edge_q     (edge_q),
   .ovf_q      (ovf_q),
   .clr_edge   (clr_edge),
   .clr_ovf    (clr_ovf),
   .ctrl_bits  (ctrl_q),
   .irq_o      (irq_o)
);

// File: tb/cni_intc_tb_top.sv
module cni_intc_tb_top;

   localparam int NCH = 24;
   localparam int AW  = 6;
   localparam logic [AW-1:0] A_CLR  = 6'h07;
   localparam logic [AW-1:0] A_STAT = 6'h14;
   localparam logic [AW-1:0] A_CTRL = 6'h15;
   localparam logic [AW-1:0] A_RISE = 6'h18;
   localparam logic [AW-1:0] A_FALL = 6'h20;

   typedef struct packed {
      logic [7:0]     ctrl;
      logic [NCH-1:0] rise;
      logic [NCH-1:0] fall;
      logic [NCH-1:0] pre;
      logic [NCH-1:0] post;
      logic           exp_edge;
   } vec_t;

   // R3 R4 R5 R9 stimulus table
   localparam vec_t VECS [0:7] = '{
      '{8'h08, 24'h000001, 24'h000000, 24'h000000, 24'h000001, 1'b1},
      '{8'h10, 24'h000000, 24'h800000, 24'hFFFFFF, 24'h7FFFFF, 1'b1},
      '{8'h10, 24'h000001, 24'h000000, 24'h000000, 24'h000001, 1'b0},
      '{8'h18, 24'h0000FF, 24'h000000, 24'h000000, 24'h000100, 1'b0},
      '{8'h1D, 24'h010000, 24'h000000, 24'h000000, 24'h010000, 1'b1},
      '{8'h0D, 24'h000000, 24'h000010, 24'h000010, 24'h000000, 1'b0},
      '{8'h1F, 24'h000000, 24'h000400, 24'h000400, 24'h000000, 1'b1},
      '{8'h19, 24'h000001, 24'h000000, 24'h000000, 24'h000001, 1'b1}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] din = '0;
   logic           wr = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic [7:0]     wdata = '0;
   logic [7:0]     rdata;
   logic           irq;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cni_intc dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .din_i       (din),
      .reg_wr_i    (wr),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_o       (irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [AW-1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic drive(input logic [NCH-1:0] v);
      @(negedge clk);
      din = v;
      @(negedge clk);
   endtask

   task automatic load_enables(input logic [NCH-1:0] r, input logic [NCH-1:0] f);
      for (int b = 0; b < 3; b++) begin
         wr_reg(A_RISE + AW'(b), r[b*8 +: 8]);
         wr_reg(A_FALL + AW'(b), f[b*8 +: 8]);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      logic [7:0] exp_st;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_reg(A_CTRL, v);            check("R1 ctrl", v, 8'h00);
      rd_reg(A_STAT, v);            check("R1 status", v, 8'h00);
      rd_reg(A_RISE + 6'd2, v);     check("R1 rise byte", v, 8'h00);
      rd_reg(A_FALL, v);            check("R1 fall byte", v, 8'h00);
      check("R1 irq", {7'b0, irq}, 8'h00);

      // R2 enable readback
      wr_reg(A_RISE, 8'hA5);
      wr_reg(A_RISE + 6'd2, 8'h3C);
      wr_reg(A_FALL + 6'd1, 8'h5A);
      rd_reg(A_RISE, v);            check("R2 rise0", v, 8'hA5);
      rd_reg(A_RISE + 6'd1, v);     check("R2 rise1", v, 8'h00);
      rd_reg(A_RISE + 6'd2, v);     check("R2 rise2", v, 8'h3C);
      rd_reg(A_FALL + 6'd1, v);     check("R2 fall1", v, 8'h5A);

      // R10 control readback
      wr_reg(A_CTRL, 8'hFF);
      rd_reg(A_CTRL, v);            check("R10 ctrl mask", v, 8'h1F);
      wr_reg(A_CTRL, 8'h00);

      // R11 status write ignored, R7 clear byte reads zero
      wr_reg(A_STAT, 8'hFF);
      rd_reg(A_STAT, v);            check("R11 status write", v, 8'h00);
      rd_reg(A_CLR, v);             check("R7 clear reads 0", v, 8'h00);

      // table walk
      for (int i = 0; i < 8; i++) begin
         wr_reg(A_CTRL, 8'h00);
         load_enables(VECS[i].rise, VECS[i].fall);
         drive(VECS[i].pre);
         wr_reg(A_CLR, 8'h0C);
         wr_reg(A_CTRL, VECS[i].ctrl);
         drive(VECS[i].post);
         exp_st = {5'b0, VECS[i].ctrl[2] & VECS[i].ctrl[0] & VECS[i].exp_edge,
                   1'b0, VECS[i].exp_edge};
         rd_reg(A_STAT, v);
         check($sformatf("R3/R4/R5/R9 vector %0d", i), v, exp_st);
      end

      // R6 overflow and R7 partial clears
      wr_reg(A_CTRL, 8'h00);
      load_enables(24'h000001, 24'h000000);
      drive(24'h000000);
      wr_reg(A_CLR, 8'h0C);
      wr_reg(A_CTRL, 8'h0F);
      drive(24'h000001);
      rd_reg(A_STAT, v);            check("R9 edge irq", v, 8'h05);
      check("R9 irq pin", {7'b0, irq}, 8'h01);
      drive(24'h000000);
      drive(24'h000001);
      rd_reg(A_STAT, v);            check("R6 overflow", v, 8'h07);
      wr_reg(A_CLR, 8'h08);
      rd_reg(A_STAT, v);            check("R7 edge clear only", v, 8'h06);
      wr_reg(A_CLR, 8'h04);
      rd_reg(A_STAT, v);            check("R7 ovf clear", v, 8'h00);
      check("R9 irq low", {7'b0, irq}, 8'h00);

      // R9 edge source enable gating
      wr_reg(A_CTRL, 8'h00);
      drive(24'h000000);
      wr_reg(A_CLR, 8'h0C);
      wr_reg(A_CTRL, 8'h0C);
      drive(24'h000001);
      rd_reg(A_STAT, v);            check("R9 edge_en off", v, 8'h01);
      wr_reg(A_CTRL, 8'h0D);
      rd_reg(A_STAT, v);            check("R9 edge_en on", v, 8'h05);
      check("R9 irq pin on", {7'b0, irq}, 8'h01);

      // R8 clear racing a new event
      wr_reg(A_CTRL, 8'h08);
      drive(24'h000000);
      @(negedge clk);
      wr = 1'b1; addr = A_CLR; wdata = 8'h0C; din = 24'h000001;
      @(negedge clk);
      wr = 1'b0;
      rd_reg(A_STAT, v);            check("R8 event wins", v, 8'h01);
      wr_reg(A_CLR, 8'h0C);
      rd_reg(A_STAT, v);            check("R7 both cleared", v, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule